// File: doc/BRIEF.md
# Line Alarm Interrupt Controller

This block gathers the alarm indications of a two-channel line interface and turns them into a single level interrupt. Each channel gives it five live alarms: receive loss of signal, receive loss of lock, analog LOS, digital LOS and pattern-checker out-of-sync. The sixth alarm, the driver monitor, is produced inside the block by a counter that watches the transmit output for pulses. Each bit period is marked by a strobe, and a pulse seen in that period resets the count.

Three of the alarms can raise an interrupt: driver monitor, receive LOS and receive loss of lock. Any change of one of these alarms, rising or falling, is latched into a sticky status bit. Each status bit is gated by a software enable, and the gated bits of both channels are ORed into the interrupt. A byte-wide register port with separate read and write strobes gives access to each channel's enable, status and alarm bytes. Reading a status byte clears it. A change that lands in the same cycle as that read is kept, so no event is lost.

Top module: `lai_ctrl`

## Requirements
- R1: Channel c (0 or 1) decodes its enable byte at address 8*c+1, its status byte at 8*c+2 and its alarm byte at 8*c+3. Any other address reads as 0x00, and writes to status, alarm or unmapped addresses change nothing. bus_rdata is loaded on the clock edge that samples bus_rd and holds its value between reads.
- R2: In the enable and status bytes, bit 0 is the driver monitor, bit 1 is receive LOS and bit 2 is receive loss of lock. Bits 7..3 ignore writes and read as 0.
- R3: After reset all enable bits, status bits and alarms are 0, and irq is low.
- R4: A status bit is set when its synchronized alarm changes level, in either direction. For a receive alarm input that changes before clock edge k, the status bit is set at edge k+2. It stays set until it is cleared by a read.
- R5: A read of the status byte returns its current value and clears it on the same edge.
- R6: The alarm byte shows the live alarms: bit 0 driver monitor, bit 1 receive LOS, bit 2 receive loss of lock, bit 4 analog LOS, bit 5 digital LOS, bit 6 out-of-sync. Bits 3 and 7 read as 0. The receive alarms pass through a two-flop synchronizer.
- R7: The driver monitor alarm rises on the edge that samples the 128th consecutive bit period (bit_tick high) without a pulse (tx_pulse low).
- R8: A bit period with a pulse (bit_tick and tx_pulse both high) clears the driver monitor alarm and restarts its count from zero.
- R9: irq is high exactly when, in some channel, a status bit and its enable bit are both 1.
- R10: If a change lands on the same edge as a read of the status byte, the read returns the old value and the new change stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 2 | Per-channel bit-period strobe |
| tx_pulse | input | 2 | Per-channel transmit pulse seen in this bit period |
| rlos_in | input | 2 | Per-channel receive loss of signal |
| rlol_in | input | 2 | Per-channel receive loss of lock |
| alos_in | input | 2 | Per-channel analog LOS |
| dlos_in | input | 2 | Per-channel digital LOS |
| prbs_oos_in | input | 2 | Per-channel pattern checker out of sync |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The change latch is driven with both rising and falling alarm levels, which separates a latch that sees every change from one that only sees assertions. Several alarms are changed at once on one channel while the other channel stays quiet, which exposes swapped bit positions and crossed channels. A change is timed to land on the very edge of a status read, which separates keeping the event from losing it. The driver monitor is read one period before and one period after its 128th empty period, and again after a pulse and a shorter run, which pins the count limit and the restart.

// File: rtl/lai_pkg.sv
package lai_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int NSRC    = 3;
  localparam logic [DATA_W-1:0] SRC_MASK = 8'h07;

  typedef enum logic [1:0] {
    REG_EN  = 2'd1,
    REG_STS = 2'd2,
    REG_ALM = 2'd3
  } reg_sel_e;

  // register address for a channel and register kind
  function automatic logic [ADDR_W-1:0] reg_addr(input int ch, input reg_sel_e r);
    return ADDR_W'(ch * 8 + int'(r));
  endfunction

  // alarm byte layout
  function automatic logic [DATA_W-1:0] pack_alarm(input logic dm, input logic rlos,
      input logic rlol, input logic alos, input logic dlos, input logic oos);
    return {1'b0, oos, dlos, alos, 1'b0, rlol, rlos, dm};
  endfunction

  // sticky status update: set wins over clear
  function automatic logic [NSRC-1:0] next_status(input logic [NSRC-1:0] cur,
      input logic [NSRC-1:0] chg, input logic clr);
    return (clr ? '0 : cur) | chg;
  endfunction
endpackage

// File: rtl/lai_sync.sv
module lai_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/lai_drvmon.sv
module lai_drvmon #(
  parameter int LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_pulse,
  output logic dm
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
    return (c == LIM) ? c : c + 1'b1;
  endfunction

  logic [CW-1:0] cnt_q;
  logic          empty_tick;
  logic          hit_tick;
  logic [CW-1:0] cnt_nxt;

  assign empty_tick = bit_tick & ~tx_pulse;
  assign hit_tick   = bit_tick & tx_pulse;
  assign cnt_nxt    = sat_inc(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dm    <= 1'b0;
    end else if (hit_tick) begin
      cnt_q <= '0;
      dm    <= 1'b0;
    end else if (empty_tick) begin
      cnt_q <= cnt_nxt;
      dm    <= (cnt_nxt == LIM);
    end
  end

  // R7: alarm only rises on an empty bit period
  a_r7_dm_rise_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dm) |-> $past(empty_tick));
  // R8: a pulse clears the alarm
  a_r8_dm_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hit_tick |=> !dm);
endmodule

// File: rtl/lai_chan.sv
module lai_chan
  import lai_pkg::*;
#(
  parameter int DM_LIMIT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_pulse,
  input  logic              rlos,
  input  logic              rlol,
  input  logic              alos,
  input  logic              dlos,
  input  logic              oos,
  input  logic              en_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sts_clr,
  output logic [DATA_W-1:0] en_o,
  output logic [DATA_W-1:0] sts_o,
  output logic [DATA_W-1:0] alm_o,
  output logic [NSRC-1:0]   chg_o,
  output logic              irq_o
);
  logic [4:0]        rx_s;
  logic              dm;
  logic [NSRC-1:0]   live;
  logic [NSRC-1:0]   prev_q;
  logic [NSRC-1:0]   sts_q;
  logic [DATA_W-1:0] en_q;

  lai_sync #(.W(5)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({oos, dlos, alos, rlol, rlos}),
    .q     (rx_s)
  );

  lai_drvmon #(.LIMIT(DM_LIMIT)) u_drvmon (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .tx_pulse (tx_pulse),
    .dm       (dm)
  );

  assign live  = {rx_s[1], rx_s[0], dm};
  assign chg_o = live ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      sts_q  <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= live;
      sts_q  <= next_status(sts_q, chg_o, sts_clr);
      if (en_wr) en_q <= wdata & SRC_MASK;
    end
  end

  assign en_o  = en_q;
  assign sts_o = {{(DATA_W-NSRC){1'b0}}, sts_q};
  assign alm_o = pack_alarm(dm, rx_s[0], rx_s[1], rx_s[2], rx_s[3], rx_s[4]);
  assign irq_o = |(sts_q & en_q[NSRC-1:0]);

  // R4: every detected change is latched
  a_r4_change_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_o != '0) |=> ((sts_q & $past(chg_o)) == $past(chg_o)));
  // R5: a read with no new change leaves status empty
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && chg_o == '0) |=> (sts_q == '0));
  // R10: a change coincident with a read survives
  a_r10_coincident_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && chg_o != '0) |=> (sts_q == $past(chg_o)));
endmodule

// File: rtl/lai_ctrl.sv
module lai_ctrl
  import lai_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int DM_LIMIT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    bit_tick,
  input  logic [NCH-1:0]    tx_pulse,
  input  logic [NCH-1:0]    rlos_in,
  input  logic [NCH-1:0]    rlol_in,
  input  logic [NCH-1:0]    alos_in,
  input  logic [NCH-1:0]    dlos_in,
  input  logic [NCH-1:0]    prbs_oos_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] en_b  [NCH];
  logic [DATA_W-1:0] sts_b [NCH];
  logic [DATA_W-1:0] alm_b [NCH];
  logic [NSRC-1:0]   chg_w [NCH];
  logic [NCH-1:0]    irq_w;
  logic [NCH-1:0]    hit_en, hit_sts, hit_alm;
  logic [DATA_W-1:0] rd_mux;
  logic              any_chg;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit_en[c]  = (bus_addr == reg_addr(c, REG_EN));
    assign hit_sts[c] = (bus_addr == reg_addr(c, REG_STS));
    assign hit_alm[c] = (bus_addr == reg_addr(c, REG_ALM));

    lai_chan #(.DM_LIMIT(DM_LIMIT)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick[c]),
      .tx_pulse (tx_pulse[c]),
      .rlos     (rlos_in[c]),
      .rlol     (rlol_in[c]),
      .alos     (alos_in[c]),
      .dlos     (dlos_in[c]),
      .oos      (prbs_oos_in[c]),
      .en_wr    (bus_wr & hit_en[c]),
      .wdata    (bus_wdata),
      .sts_clr  (bus_rd & hit_sts[c]),
      .en_o     (en_b[c]),
      .sts_o    (sts_b[c]),
      .alm_o    (alm_b[c]),
      .chg_o    (chg_w[c]),
      .irq_o    (irq_w[c])
    );
  end

  always_comb begin
    rd_mux  = '0;
    any_chg = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (hit_en[c])  rd_mux = rd_mux | en_b[c];
      if (hit_sts[c]) rd_mux = rd_mux | sts_b[c];
      if (hit_alm[c]) rd_mux = rd_mux | alm_b[c];
      any_chg = any_chg | (|chg_w[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq = |irq_w;

  // R9: interrupt only rises after a change or an enable write
  a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_chg || bus_wr));
  // R9: interrupt only falls after a read or an enable write
  a_r9_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_rd || bus_wr));
endmodule

// File: tb/lai_ctrl_tb.sv
module lai_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bit_tick = 2'b11, tx_pulse = 2'b11;
  logic [1:0] rlos_in = '0, rlol_in = '0, alos_in = '0, dlos_in = '0, prbs_oos_in = '0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  lai_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_pulse(tx_pulse),
    .rlos_in(rlos_in), .rlol_in(rlol_in), .alos_in(alos_in), .dlos_in(dlos_in),
    .prbs_oos_in(prbs_oos_in), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R3 irq after reset", {7'd0, irq}, 8'h00);
    bus_read(8'h01, d); chk("R3 ch0 enable reset", d, 8'h00);
    bus_read(8'h09, d); chk("R3 ch1 enable reset", d, 8'h00);
    bus_read(8'h0A, d); chk("R3 ch1 status reset", d, 8'h00);
    bus_read(8'h03, d); chk("R3 ch0 alarm reset", d, 8'h00);
  endtask

  task automatic t_map();
    logic [7:0] d;
    bus_write(8'h01, 8'hFF);
    bus_read(8'h01, d); chk("R2 reserved enable bits", d, 8'h07);
    bus_write(8'h09, 8'h05);
    bus_read(8'h09, d); chk("R1 ch1 enable", d, 8'h05);
    bus_read(8'h01, d); chk("R1 ch0 enable kept", d, 8'h07);
    bus_write(8'h03, 8'hFF);
    bus_read(8'h03, d); chk("R1 alarm write ignored", d, 8'h00);
    bus_write(8'h0A, 8'hFF);
    bus_read(8'h0A, d); chk("R1 status write ignored", d, 8'h00);
    bus_write(8'h05, 8'hFF);
    bus_read(8'h05, d); chk("R1 unmapped read", d, 8'h00);
    bus_read(8'h01, d); chk("R1 unmapped write no effect", d, 8'h07);
    chk("R1 rdata holds", bus_rdata, 8'h07);
    bus_write(8'h01, 8'h00);
    bus_write(8'h09, 8'h00);
  endtask

  task automatic t_alarm();
    logic [7:0] d;
    @(negedge clk);
    rlos_in[1] = 1; rlol_in[1] = 1; alos_in[1] = 1; dlos_in[1] = 1; prbs_oos_in[1] = 1;
    settle();
    bus_read(8'h0B, d); chk("R6 ch1 alarm layout", d, 8'h76);
    bus_read(8'h03, d); chk("R6 ch0 alarm quiet", d, 8'h00);
    bus_read(8'h0A, d); chk("R4 ch1 status on rise", d, 8'h06);
    bus_read(8'h0A, d); chk("R5 status cleared by read", d, 8'h00);
    bus_read(8'h02, d); chk("R2 ch0 status untouched", d, 8'h00);
    rlos_in[1] = 0; rlol_in[1] = 0; alos_in[1] = 0; dlos_in[1] = 0; prbs_oos_in[1] = 0;
    settle();
    bus_read(8'h0A, d); chk("R4 ch1 status on fall", d, 8'h06);
    bus_read(8'h0B, d); chk("R6 ch1 alarm cleared", d, 8'h00);
    bus_read(8'h0A, d); chk("R5 status cleared again", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    bus_write(8'h01, 8'h02);
    rlos_in[0] = 1;
    settle();
    chk("R9 irq on enabled source", {7'd0, irq}, 8'h01);
    bus_read(8'h02, d); chk("R9 status source", d, 8'h02);
    chk("R9 irq drops after read", {7'd0, irq}, 8'h00);
    rlol_in[0] = 1;
    settle();
    chk("R9 masked source no irq", {7'd0, irq}, 8'h00);
    bus_read(8'h02, d); chk("R2 rlol status bit", d, 8'h04);
    rlos_in[0] = 0; rlol_in[0] = 0;
    settle();
    chk("R9 irq on falling alarm", {7'd0, irq}, 8'h01);
    bus_write(8'h01, 8'h00);
    chk("R9 irq off when disabled", {7'd0, irq}, 8'h00);
    bus_read(8'h02, d); chk("R4 both falls latched", d, 8'h06);
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    rlol_in[1] = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_read(8'h0A, d); chk("R10 read returns old value", d, 8'h00);
    bus_read(8'h0A, d); chk("R10 change kept", d, 8'h04);
    rlol_in[1] = 0;
    settle();
    bus_read(8'h0A, d); chk("R4 ch1 fall", d, 8'h04);
  endtask

  task automatic t_drvmon();
    logic [7:0] d;
    tx_pulse[0] = 0;
    repeat (127) @(posedge clk);
    @(negedge clk);
    bus_read(8'h03, d); chk("R7 no alarm after 127 periods", d, 8'h00);
    bus_read(8'h03, d); chk("R7 alarm after 128 periods", d, 8'h01);
    bus_read(8'h02, d); chk("R4 dm status set", d, 8'h01);
    tx_pulse[0] = 1;
    @(negedge clk);
    tx_pulse[0] = 0;
    bus_read(8'h03, d); chk("R8 pulse clears alarm", d, 8'h00);
    repeat (100) @(negedge clk);
    bus_read(8'h03, d); chk("R8 count restarted", d, 8'h00);
    tx_pulse[0] = 1;
    bus_read(8'h02, d); chk("R4 dm fall latched", d, 8'h01);
    bus_read(8'h0B, d); chk("R7 ch1 dm quiet", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_alarm();
    t_irq();
    t_coincide();
    t_drvmon();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule